// File: doc/BRIEF.md
# Privilege-Qualified Event Counter with Overflow Interrupt

This block is a 32-bit event counter for a processor core. A control register picks one event strobe out of a numbered set. Code 0 stands for every clock cycle. The other codes index one-bit strobes that a pipeline model supplies. The same register sets whether counting is allowed in kernel mode, in user mode, and overall. On each cycle the block looks at the current privilege level and the selected strobe, and advances the count when all qualifications hold.

When the count wraps from all ones to zero, the block latches an interrupt request. That request is offered as pending line 13 of the core's interrupt system. It is delivered only when the global interrupt enable is set and the line-13 mask bit allows it. Software can preload the count so that an overflow happens after a chosen number of cycles, which gives a second timer. If software keeps reloading the count and the reloads stop, the overflow fires and the counter acts as a watchdog.

A small register port reaches three locations: control, count and interrupt status. Reads are combinational. Writes take effect at the clock edge.

Top module: `pmon_event_counter`

## Requirements
- R1: After reset, the control register, the count and the pending request all read as zero, and `irq_pend_o` and `irq_o` are low.
- R2: A write to address 0 stores the event code in bits 4..0, the kernel enable in bit 8, the user enable in bit 9 and the master enable in bit 10. Reading address 0 returns these fields in the same positions. All other bits read as zero, whatever was written to them.
- R3: With the master enable (bit 10) set, the count increases by exactly one on each cycle where the strobe `evt_i[code]` is high and the enable for the current mode is set. The kernel enable is bit 8, used when `priv_kernel_i`=1. The user enable is bit 9, used when `priv_kernel_i`=0.
- R4: Event code 0 counts every qualified cycle, whatever value `evt_i` has.
- R5: An event code of 31 (0x1F, above the last valid code 30) never advances the count.
- R6: If the master enable is clear, or the enable for the current mode is clear, the count does not change.
- R7: A qualified increment from 0xFFFFFFFF gives a count of 0. From the next cycle, the pending request is set: it shows on `irq_pend_o` and in bit 0 of address 2.
- R8: The pending request stays set until software writes the count (address 1) or writes address 2 with bit 0 = 1. If a wrap and a clear happen in the same cycle, the request ends up set.
- R9: A write to address 1 loads the written value into the count. It overrides any increment in the same cycle and produces no wrap in that cycle.
- R10: `irq_o` is high exactly when the pending request is set, `glb_irq_en_i` is 1 and `irq_mask13_i` is 1.
- R11: With code 0 selected, reloading the count at intervals shorter than the distance to overflow keeps the request clear. Once the reloads stop, the request sets after the remaining number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT (31) | Event strobes, indexed by event code; bit 0 unused while code 0 counts cycles |
| priv_kernel_i | input | 1 | Current privilege: 1 kernel, 0 user |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 count, 2 interrupt status |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Combinational read data |
| glb_irq_en_i | input | 1 | Global interrupt enable |
| irq_mask13_i | input | 1 | Mask bit for line 13, 1 allows delivery |
| irq_pend_o | output | 1 | Pending request, line 13 |
| irq_o | output | 1 | Delivered interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- a wrap from all ones always sets the pending request;
- the request holds until a clear or a count write;
- a count write always loads its value;
- a disabled counter stays still;
- reserved control bits read as zero;
- the delivered interrupt stays gated by the enable and the mask.

The bench's scenarios are needed for the rest:
- the choice of event code, including code 0 and the invalid code;
- the privilege qualification of individual strobes;
- the order of clear against wrap;
- the watchdog timing of periodic reloads against a lapse.

The bench's reference model follows every register value over a long stream of random traffic.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   localparam int unsigned SEL_W   = 5;
   localparam int unsigned KEN_BIT = 8;
   localparam int unsigned UEN_BIT = 9;
   localparam int unsigned RUN_BIT = 10;

   typedef enum logic [1:0] {
      PM_A_CTRL  = 2'd0,
      PM_A_COUNT = 2'd1,
      PM_A_IRQ   = 2'd2,
      PM_A_NONE  = 2'd3
   } pm_addr_e;

   typedef struct packed {
      logic             run;
      logic             user_en;
      logic             kern_en;
      logic [SEL_W-1:0] sel;
   } pm_ctrl_t;
endpackage

// File: rtl/pmon_ctrl_reg.sv
module pmon_ctrl_reg
   import pmon_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output pm_ctrl_t          ctrl_o,
   output logic [DATA_W-1:0] rdata_o
);
   pm_ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.sel     <= wdata[SEL_W-1:0];
         ctrl_q.kern_en <= wdata[KEN_BIT];
         ctrl_q.user_en <= wdata[UEN_BIT];
         ctrl_q.run     <= wdata[RUN_BIT];
      end
   end

   always_comb begin
      rdata_o               = '0;
      rdata_o[SEL_W-1:0]    = ctrl_q.sel;
      rdata_o[KEN_BIT]      = ctrl_q.kern_en;
      rdata_o[UEN_BIT]      = ctrl_q.user_en;
      rdata_o[RUN_BIT]      = ctrl_q.run;
   end

   assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pmon_event_sel.sv
module pmon_event_sel
   import pmon_pkg::*;
#(
   parameter int unsigned NUM_EVT     = 31,
   parameter bit          CYCLE_CODE0 = 1'b1
) (
   input  pm_ctrl_t           ctrl_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               kernel_i,
   output logic               inc_o
);
   localparam int unsigned NCODE = 2 ** SEL_W;

   logic [NCODE-1:0] code_vec;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      if (c == 0 && CYCLE_CODE0) begin : g_cyc
         assign code_vec[c] = 1'b1;
      end else if (c < NUM_EVT) begin : g_evt
         assign code_vec[c] = evt_i[c];
      end else begin : g_none
         assign code_vec[c] = 1'b0;
      end
   end

   if (CYCLE_CODE0) begin : g_unused0
      logic unused_bit0;
      assign unused_bit0 = evt_i[0];
   end

   logic mode_ok;
   assign mode_ok = kernel_i ? ctrl_i.kern_en : ctrl_i.user_en;
   assign inc_o   = ctrl_i.run & mode_ok & code_vec[ctrl_i.sel];
endmodule

// File: rtl/pmon_count.sv
module pmon_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             pend_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             pend_q;
   logic             wrap;

   assign wrap = inc_i & ~load_i & (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         if (load_i) begin
            cnt_q <= load_val_i;
         end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
         pend_q <= wrap | (pend_q & ~clr_i & ~load_i);
      end
   end

   assign cnt_o  = cnt_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/pmon_event_counter.sv
module pmon_event_counter
   import pmon_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NUM_EVT     = 31,
   parameter bit          CYCLE_CODE0 = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               priv_kernel_i,
   input  logic               reg_wr_i,
   input  logic [1:0]         reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic               glb_irq_en_i,
   input  logic               irq_mask13_i,
   output logic               irq_pend_o,
   output logic               irq_o
);
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("CNT_W must not exceed DATA_W");
   end
   if (NUM_EVT > 2 ** SEL_W || NUM_EVT < 1) begin : g_chk_evt
      $error("NUM_EVT must fit the event code field");
   end
   if (DATA_W <= RUN_BIT) begin : g_chk_data
      $error("DATA_W too narrow for control fields");
   end

   pm_addr_e addr;
   assign addr = pm_addr_e'(reg_addr_i);

   logic wr_ctrl, wr_cnt, clr_req, inc;
   assign wr_ctrl = reg_wr_i & (addr == PM_A_CTRL);
   assign wr_cnt  = reg_wr_i & (addr == PM_A_COUNT);
   assign clr_req = reg_wr_i & (addr == PM_A_IRQ) & reg_wdata_i[0];

   pm_ctrl_t          ctrl;
   logic [DATA_W-1:0] ctrl_rd;
   logic [CNT_W-1:0]  cnt;
   logic              pend;

   pmon_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ctrl),
      .wdata   (reg_wdata_i),
      .ctrl_o  (ctrl),
      .rdata_o (ctrl_rd)
   );

   pmon_event_sel #(.NUM_EVT(NUM_EVT), .CYCLE_CODE0(CYCLE_CODE0)) u_sel (
      .ctrl_i   (ctrl),
      .evt_i    (evt_i),
      .kernel_i (priv_kernel_i),
      .inc_o    (inc)
   );

   pmon_count #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc),
      .load_i     (wr_cnt),
      .load_val_i (reg_wdata_i[CNT_W-1:0]),
      .clr_i      (clr_req),
      .cnt_o      (cnt),
      .pend_o     (pend)
   );

   always_comb begin
      reg_rdata_o = '0;
      unique case (addr)
         PM_A_CTRL:  reg_rdata_o = ctrl_rd;
         PM_A_COUNT: reg_rdata_o[CNT_W-1:0] = cnt;
         PM_A_IRQ:   reg_rdata_o[0] = pend;
         default:    reg_rdata_o = '0;
      endcase
   end

   assign irq_pend_o = pend;
   assign irq_o      = pend & glb_irq_en_i & irq_mask13_i;
endmodule

// File: rtl/pmon_event_counter_chk.sv
module pmon_event_counter_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              inc,
   input logic              wr_cnt,
   input logic              clr_req,
   input logic              run,
   input logic              mode_kern_en,
   input logic              mode_user_en,
   input logic              priv_kernel_i,
   input logic [1:0]        reg_addr_i,
   input logic [DATA_W-1:0] reg_wdata_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic [CNT_W-1:0]  cnt,
   input logic              irq_pend_o,
   input logic              irq_o,
   input logic              glb_irq_en_i,
   input logic              irq_mask13_i
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   // R7: a qualified step from all ones raises the request
   a_r7_wrap_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !wr_cnt && cnt == CMAX) |=> (irq_pend_o && cnt == '0));

   // R8: request holds until cleared or count written
   a_r8_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_o && !clr_req && !wr_cnt) |=> irq_pend_o);

   // R9: a count write loads the written value
   a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> (cnt == $past(reg_wdata_i[CNT_W-1:0])));

   // R6: disabled counter keeps its value
   a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cnt && (!run || (priv_kernel_i ? !mode_kern_en : !mode_user_en)))
      |=> $stable(cnt));

   // R2: reserved control bits read zero
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == 2'd0) |-> (reg_rdata_o[DATA_W-1:11] == '0 && reg_rdata_o[7:5] == 3'b0));

   // R10: delivery needs pending, enable and mask
   a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_pend_o && glb_irq_en_i && irq_mask13_i));
endmodule

bind pmon_event_counter pmon_event_counter_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .inc           (inc),
   .wr_cnt        (wr_cnt),
   .clr_req       (clr_req),
   .run           (ctrl.run),
   .mode_kern_en  (ctrl.kern_en),
   .mode_user_en  (ctrl.user_en),
   .priv_kernel_i (priv_kernel_i),
   .reg_addr_i    (reg_addr_i),
   .reg_wdata_i   (reg_wdata_i),
   .reg_rdata_o   (reg_rdata_o),
   .cnt           (cnt),
   .irq_pend_o    (irq_pend_o),
   .irq_o         (irq_o),
   .glb_irq_en_i  (glb_irq_en_i),
   .irq_mask13_i  (irq_mask13_i)
);

// File: tb/pmon_event_counter_bench.sv
module pmon_event_counter_bench;
   localparam int NE = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt_i = '0;
   logic          priv_kernel_i = 1'b1;
   logic          reg_wr_i = 1'b0;
   logic [1:0]    reg_addr_i = 2'd0;
   logic [31:0]   reg_wdata_i = '0;
   logic [31:0]   reg_rdata_o;
   logic          glb_irq_en_i = 1'b0;
   logic          irq_mask13_i = 1'b0;
   logic          irq_pend_o, irq_o;

   always #4 clk = ~clk;

   pmon_event_counter u_pmon_event_counter (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .priv_kernel_i(priv_kernel_i),
      .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .glb_irq_en_i(glb_irq_en_i),
      .irq_mask13_i(irq_mask13_i), .irq_pend_o(irq_pend_o), .irq_o(irq_o)
   );

   int checks = 0;
   int failures = 0;
   logic [31:0] m_ctrl = '0;
   logic [31:0] m_cnt = '0;
   logic        m_pend = 1'b0;

   function automatic logic [31:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return m_ctrl;
         2'd1: return m_cnt;
         2'd2: return {31'b0, m_pend};
         default: return '0;
      endcase
   endfunction

   function automatic logic exp_inc(input logic [31:0] c, input logic [NE-1:0] e, input logic k);
      logic [4:0] code;
      code = c[4:0];
      if (!c[10]) return 1'b0;
      if (k ? !c[8] : !c[9]) return 1'b0;
      if (code > 5'd30) return 1'b0;
      if (code == 5'd0) return 1'b1;
      return e[code];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, check combinational outputs, advance model at posedge
   task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] wd,
                       input logic [NE-1:0] e, input logic k, input logic ie,
                       input logic mk, input string req);
      logic inc, cw, clr, wrap;
      @(negedge clk);
      reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd; evt_i = e;
      priv_kernel_i = k; glb_irq_en_i = ie; irq_mask13_i = mk;
      #1;
      check(req, reg_rdata_o, exp_read(a));
      check(req, {31'b0, irq_pend_o}, {31'b0, m_pend});
      check("R10", {31'b0, irq_o}, {31'b0, m_pend & ie & mk});
      inc  = exp_inc(m_ctrl, e, k);
      cw   = wr && a == 2'd1;
      clr  = wr && a == 2'd2 && wd[0];
      wrap = inc && !cw && m_cnt == 32'hFFFF_FFFF;
      @(posedge clk);
      m_pend = wrap | (m_pend & !clr & !cw);
      if (cw) m_cnt = wd;
      else if (inc) m_cnt = m_cnt + 1;
      if (wr && a == 2'd0) m_ctrl = wd & 32'h0000_071F;
   endtask

   task automatic idle(input logic [1:0] a, input logic [NE-1:0] e, input logic k, input string req);
      step(1'b0, a, 32'h0, e, k, 1'b1, 1'b1, req);
   endtask

   initial begin
      #(8 * 150000);
      failures++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'h5EED_1234);
      #20 rst_n = 1'b1;
      // R1: reset values
      idle(2'd0, '0, 1'b1, "R1");
      idle(2'd1, '0, 1'b1, "R1");
      idle(2'd2, '0, 1'b1, "R1");
      // R2: reserved bits dropped
      step(1'b1, 2'd0, 32'hFFFF_FFFF, '0, 1'b1, 1'b0, 1'b0, "R2");
      idle(2'd0, '0, 1'b1, "R2");
      // R4: code 0 counts with no strobes, kernel only
      step(1'b1, 2'd0, 32'h0000_0500, '0, 1'b1, 1'b0, 1'b0, "R4");
      step(1'b1, 2'd1, 32'h0, '0, 1'b1, 1'b0, 1'b0, "R4");
      for (int i = 0; i < 5; i++) idle(2'd1, '0, 1'b1, "R4");
      // R6: user mode with kernel-only enable does not count
      for (int i = 0; i < 4; i++) idle(2'd1, '1, 1'b0, "R6");
      // R6: master enable off
      step(1'b1, 2'd0, 32'h0000_0300, '1, 1'b1, 1'b0, 1'b0, "R6");
      for (int i = 0; i < 4; i++) idle(2'd1, '1, 1'b1, "R6");
      // R3: code 7 strobe in user mode
      step(1'b1, 2'd0, 32'h0000_0607, '0, 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < 8; i++) idle(2'd1, NE'(i[0]) << 7, 1'b0, "R3");
      for (int i = 0; i < 4; i++) idle(2'd1, ~(NE'(1) << 7), 1'b0, "R3");
      // R5: invalid code 31
      step(1'b1, 2'd0, 32'h0000_071F, '1, 1'b1, 1'b0, 1'b0, "R5");
      for (int i = 0; i < 4; i++) idle(2'd1, '1, 1'b1, "R5");
      // R7: wrap sets pending; R10 gating
      step(1'b1, 2'd0, 32'h0000_0500, '0, 1'b1, 1'b0, 1'b0, "R7");
      step(1'b1, 2'd1, 32'hFFFF_FFFE, '0, 1'b1, 1'b0, 1'b0, "R7");
      for (int i = 0; i < 4; i++) idle(2'd2, '0, 1'b1, "R7");
      step(1'b0, 2'd2, 32'h0, '0, 1'b1, 1'b0, 1'b1, "R10");
      step(1'b0, 2'd2, 32'h0, '0, 1'b1, 1'b1, 1'b0, "R10");
      // R8: clear via address 2, then clear coinciding with wrap
      step(1'b1, 2'd2, 32'h1, '0, 1'b1, 1'b1, 1'b1, "R8");
      idle(2'd2, '0, 1'b1, "R8");
      step(1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 1'b1, "R8");
      step(1'b1, 2'd2, 32'h1, '0, 1'b1, 1'b1, 1'b1, "R8");
      idle(2'd2, '0, 1'b1, "R8");
      // R9: count write clears pending and beats increment
      step(1'b1, 2'd1, 32'h1234_5678, '0, 1'b1, 1'b1, 1'b1, "R9");
      idle(2'd1, '0, 1'b1, "R9");
      step(1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 1'b1, "R9");
      step(1'b1, 2'd1, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 1'b1, "R9");
      idle(2'd2, '0, 1'b1, "R9");
      // R11: watchdog reloads keep quiet, lapse fires
      for (int r = 0; r < 10; r++) begin
         step(1'b1, 2'd1, 32'hFFFF_FFFF - 32'd60, '0, 1'b1, 1'b1, 1'b1, "R11");
         for (int i = 0; i < 40; i++) idle(2'd2, '0, 1'b1, "R11");
      end
      for (int i = 0; i < 66; i++) idle(2'd2, '0, 1'b1, "R11");
      // random traffic against the model (R3)
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] wd;
         logic [1:0]  a;
         logic        wr;
         wr = ($urandom % 8) == 0;
         a  = 2'($urandom % 4);
         wd = $urandom;
         if (wr && a == 2'd1 && $urandom % 2) wd = 32'hFFFF_FFF0 | (wd & 32'hF);
         if (wr && a == 2'd0) wd = (wd & 32'hFFFF_FF00) | 32'h0400 | ($urandom % 34 > 31 ? 32'h0 : (wd & 32'h1F));
         step(wr, a, wd, NE'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R3");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule